// File: doc/BRIEF.md
# Interleaved I/Q Word Serializer

This block drains a first-word-fall-through FIFO of 32-bit samples that arrive as alternating in-phase and quadrature words. Each word is sent one bit per clock, most significant bit first. In-phase words leave on one serial pin and quadrature words on a second pin. Each pin has its own valid strobe, which is high for exactly the 32 cycles of a word so that a receiver can find the word boundaries. The FIFO (512 words deep in the intended system) sits outside the block. The block drives only its read strobe and watches its data, empty and full flags.

A one-bit phase register decides which pin the next word goes to. It flips each time a word is taken. If the FIFO runs dry at a word boundary, both lines idle low and the phase register keeps its value, so the I/Q pairing survives the gap. While the FIFO reports full, an overflow pin goes high and both data pins and both strobes are forced low. The overflow pin stays high after full drops, until a synchronous clear input acknowledges it.

Top module: `iq_word_serializer`

## Requirements
- R1: While reset is asserted, all serial, valid, read and overflow outputs are low, and the first word taken after reset is routed as an in-phase word.
- R2: The read strobe `fifo_rd_o` is never high in a cycle where `fifo_empty_i` is high.
- R3: Words are routed strictly alternately: the first word after reset goes to `i_ser_o`, the next to `q_ser_o`, and so on.
- R4: In the cycle after a word is popped, its bit 31 appears on its pin. Each later cycle presents the next lower bit, and bit 0 appears in the 32nd cycle.
- R5: A new word is popped only in the cycle that shows bit 0 of the current word, or when no word is in flight. With data waiting, words follow with no idle cycle. Each valid strobe is high for exactly 32 consecutive cycles per word, and the two strobes are never high together.
- R6: When the FIFO is empty at a word boundary, both serial pins and both valid strobes are low, and the phase is held: after the gap, the next word goes to the pin that follows the last word sent.
- R7: In any cycle where `fifo_full_i` is high, `ovf_o` is high and `i_ser_o`, `q_ser_o`, `i_vld_o` and `q_vld_o` are all low. Shifting continues underneath.
- R8: `ovf_o` stays high after `fifo_full_i` falls, until `ovf_clr_i` is sampled high at a clock edge while `fifo_full_i` is low. A clear that coincides with full has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_data_i | input | 32 | Head word of the FIFO (first-word-fall-through) |
| fifo_empty_i | input | 1 | FIFO has no word |
| fifo_full_i | input | 1 | FIFO has no free slot |
| fifo_rd_o | output | 1 | Pops the head word at the clock edge |
| ovf_clr_i | input | 1 | Synchronous clear of the sticky overflow flag |
| i_ser_o | output | 1 | In-phase serial data, MSB first |
| i_vld_o | output | 1 | High while an in-phase word is on `i_ser_o` |
| q_ser_o | output | 1 | Quadrature serial data, MSB first |
| q_vld_o | output | 1 | High while a quadrature word is on `q_ser_o` |
| ovf_o | output | 1 | Overflow indicator (live full or sticky) |

## Verification
The bench targets the word boundary. A design that pops one cycle early or late would drop or repeat a bit, or insert a bubble between back-to-back words. The bench therefore checks the exact cycle of each pop and reassembles every word at a receiver that counts strobe run lengths. An empty gap after an odd number of words shows whether the phase is held: a design that flips phase while idle would send the next word to the wrong pin. Full is pulsed mid-word, alone and together with the clear input. A design that blanks late, that forgets the flag once full falls, or that lets a clear override a live full would be caught.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  typedef enum logic {
    PH_I = 1'b0,
    PH_Q = 1'b1
  } iq_phase_e;

  function automatic iq_phase_e other_phase(input iq_phase_e ph);
    return (ph == PH_I) ? PH_Q : PH_I;
  endfunction
endpackage

// File: rtl/iq_fetch_ctrl.sv
module iq_fetch_ctrl
  import iq_ser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fifo_empty_i,
  output logic      load_o,
  output logic      busy_o,
  output iq_phase_e word_phase_o
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  iq_phase_e        next_ph_q, next_ph_d;
  iq_phase_e        word_ph_q, word_ph_d;
  logic             last_bit;

  // last bit of the word in flight is on the pin this cycle
  assign last_bit = busy_q && (cnt_q == LAST_BIT);
  assign load_o   = !fifo_empty_i && (!busy_q || last_bit);

  always_comb begin
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    next_ph_d = next_ph_q;
    word_ph_d = word_ph_q;
    if (load_o) begin
      cnt_d     = '0;
      busy_d    = 1'b1;
      word_ph_d = next_ph_q;
      next_ph_d = other_phase(next_ph_q);
    end else if (last_bit) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      next_ph_q <= PH_I;
      word_ph_q <= PH_I;
    end else begin
      cnt_q     <= cnt_d;
      busy_q    <= busy_d;
      next_ph_q <= next_ph_d;
      word_ph_q <= word_ph_d;
    end
  end

  assign busy_o       = busy_q;
  assign word_phase_o = word_ph_q;

  // R2: never pop from an empty FIFO
  a_r2_no_pop_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_i |-> !load_o);

  // R5: a pop during a word happens only on its last bit
  a_r5_pop_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && busy_q) |-> (cnt_q == LAST_BIT));

  // R6: the routing phase does not move unless a word is taken
  a_r6_phase_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(next_ph_q));

  // R3: the word just loaded and the one after it go to different pins
  a_r3_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (word_ph_q != next_ph_q));
endmodule

// File: rtl/iq_shift_reg.sv
module iq_shift_reg #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sh_en;

  assign sh_en = load_i || shift_i;

  always_comb begin
    sh_d = sh_q;
    if (load_i)       sh_d = data_i;
    else if (shift_i) sh_d = {sh_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign msb_o = sh_q[WORD_W-1];
endmodule

// File: rtl/iq_out_route.sv
module iq_out_route
  import iq_ser_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      busy_i,
  input  iq_phase_e word_phase_i,
  input  logic      bit_i,
  input  logic      full_i,
  input  logic      clr_i,
  output logic      i_ser_o,
  output logic      i_vld_o,
  output logic      q_ser_o,
  output logic      q_vld_o,
  output logic      ovf_o
);
  logic sticky_q, sticky_d;
  logic live;

  assign live    = busy_i && !full_i;
  assign i_vld_o = live && (word_phase_i == PH_I);
  assign q_vld_o = live && (word_phase_i == PH_Q);
  assign i_ser_o = i_vld_o && bit_i;
  assign q_ser_o = q_vld_o && bit_i;

  always_comb begin
    sticky_d = sticky_q;
    if (full_i)     sticky_d = 1'b1;
    else if (clr_i) sticky_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= 1'b0;
    else         sticky_q <= sticky_d;
  end

  assign ovf_o = sticky_q || full_i;

  // R5: never both strobes at once
  a_r5_one_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(i_vld_o && q_vld_o));

  // R7: full blanks both data lanes
  a_r7_full_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> (ovf_o && !i_ser_o && !q_ser_o && !i_vld_o && !q_vld_o));

  // R8: the flag survives until a clear without full
  a_r8_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);
endmodule

// File: rtl/iq_word_serializer.sv
module iq_word_serializer
  import iq_ser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  output logic              fifo_rd_o,
  input  logic              ovf_clr_i,
  output logic              i_ser_o,
  output logic              i_vld_o,
  output logic              q_ser_o,
  output logic              q_vld_o,
  output logic              ovf_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;
  logic                   load;
  logic                   busy;
  logic                   msb;
  iq_phase_e              word_phase;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  iq_fetch_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .fifo_empty_i (fifo_empty_i),
    .load_o       (load),
    .busy_o       (busy),
    .word_phase_o (word_phase)
  );

  iq_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (load),
    .shift_i (busy),
    .data_i  (fifo_data_i),
    .msb_o   (msb)
  );

  iq_out_route u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .busy_i       (busy),
    .word_phase_i (word_phase),
    .bit_i        (msb),
    .full_i       (fifo_full_i),
    .clr_i        (ovf_clr_i),
    .i_ser_o      (i_ser_o),
    .i_vld_o      (i_vld_o),
    .q_ser_o      (q_ser_o),
    .q_vld_o      (q_vld_o),
    .ovf_o        (ovf_o)
  );

  assign fifo_rd_o = load && rst_n;

  // R4: the popped word's top bit is on the pin one cycle later
  a_r4_msb_first: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_rd_o |=> (fifo_full_i || ((i_ser_o || q_ser_o) == $past(fifo_data_i[WORD_W-1]))));

  // R5: a pop always lights exactly one strobe next cycle (unless blanked)
  a_r5_pop_lights_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    fifo_rd_o |=> (fifo_full_i || $onehot({i_vld_o, q_vld_o})));
endmodule

// File: tb/iq_word_serializer_tb.sv
module iq_word_serializer_tb_top;
  localparam int W = 32;
  localparam int NVEC = 8;
  localparam logic [W-1:0] VEC [NVEC] = '{
    32'h8000_0001, 32'h7FFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0000,
    32'hA5A5_5A5A, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0
  };

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic         rst_ni, fifo_full_i, ovf_clr_i;
  logic [W-1:0] fifo_data_i;
  logic         fifo_empty_i, fifo_rd_o;
  logic         i_ser_o, i_vld_o, q_ser_o, q_vld_o, ovf_o;

  logic [W-1:0] mem [64];
  int wp = 0;
  int rp = 0;
  assign fifo_empty_i = (wp == rp);
  assign fifo_data_i  = mem[rp[5:0]];
  always @(posedge clk_i) if (fifo_rd_o) rp <= rp + 1;

  iq_word_serializer #(.WORD_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fifo_data_i(fifo_data_i),
    .fifo_empty_i(fifo_empty_i), .fifo_full_i(fifo_full_i),
    .fifo_rd_o(fifo_rd_o), .ovf_clr_i(ovf_clr_i),
    .i_ser_o(i_ser_o), .i_vld_o(i_vld_o), .q_ser_o(q_ser_o),
    .q_vld_o(q_vld_o), .ovf_o(ovf_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] i_rx [16];
  logic [W-1:0] q_rx [16];
  logic [W-1:0] i_sh, q_sh;
  int i_n, q_n, i_cnt, q_cnt, misframe, bubble, rd_empty_err;
  bit started;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_clear();
    i_n = 0; q_n = 0; i_cnt = 0; q_cnt = 0; misframe = 0;
    bubble = 0; rd_empty_err = 0; started = 0;
  endtask

  task automatic push(input logic [W-1:0] w);
    mem[wp[5:0]] = w;
    wp++;
  endtask

  // receiver model: rebuild words from each strobe, count framing errors
  always @(negedge clk_i) begin
    if (i_vld_o) begin
      i_sh = {i_sh[W-2:0], i_ser_o};
      if (i_cnt == W-1) begin i_rx[i_n[3:0]] = i_sh; i_n++; i_cnt = 0; end
      else i_cnt++;
    end else if (i_cnt != 0) begin misframe++; i_cnt = 0; end
    if (q_vld_o) begin
      q_sh = {q_sh[W-2:0], q_ser_o};
      if (q_cnt == W-1) begin q_rx[q_n[3:0]] = q_sh; q_n++; q_cnt = 0; end
      else q_cnt++;
    end else if (q_cnt != 0) begin misframe++; q_cnt = 0; end
    if (fifo_rd_o && fifo_empty_i) rd_empty_err++;
    if (started && !i_vld_o && !q_vld_o && !fifo_empty_i) bubble++;
    if (i_vld_o || q_vld_o) started = 1;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic [W-1:0] wa, wb;
    rst_ni = 1'b0; fifo_full_i = 1'b0; ovf_clr_i = 1'b0;
    rx_clear();
    repeat (3) @(negedge clk_i);
    // R1: quiet outputs in reset
    chk({i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o, ovf_o} == 6'b0, "R1 reset outputs",
        {26'b0, i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o, ovf_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R4/R3/R5: exact timing of two words
    wa = 32'hC3A5_0F1E; wb = 32'h5A5A_A5A5;
    push(wa); push(wb);
    #1 chk(fifo_rd_o == 1'b1, "R5 pop when idle", {31'b0, fifo_rd_o}, 1);
    @(negedge clk_i);
    chk(i_vld_o && !q_vld_o, "R3 first word on I pin", {30'b0, i_vld_o, q_vld_o}, 2);
    chk(i_ser_o == wa[31], "R4 msb first", {31'b0, i_ser_o}, {31'b0, wa[31]});
    chk(fifo_rd_o == 1'b0, "R5 no pop mid-word", {31'b0, fifo_rd_o}, 0);
    for (int k = 1; k < W; k++) begin
      @(negedge clk_i);
      chk(i_ser_o == wa[W-1-k], "R4 bit order", {31'b0, i_ser_o}, {31'b0, wa[W-1-k]});
    end
    chk(fifo_rd_o == 1'b1, "R5 pop on last bit", {31'b0, fifo_rd_o}, 1);
    @(negedge clk_i);
    chk(q_vld_o && !i_vld_o && q_ser_o == wb[31], "R3 second word on Q pin",
        {29'b0, i_vld_o, q_vld_o, q_ser_o}, {30'b0, 1'b1, wb[31]});
    repeat (40) @(negedge clk_i);
    chk(i_rx[0] == wa && q_rx[0] == wb && i_n == 1 && q_n == 1, "R3 pair received", i_rx[0], wa);

    // table walk: back-to-back stream
    @(posedge clk_i); rx_clear();
    @(negedge clk_i);
    for (int v = 0; v < NVEC; v++) push(VEC[v]);
    repeat (NVEC * W + 10) @(negedge clk_i);
    for (int v = 0; v < NVEC; v += 2) begin
      chk(i_rx[v/2] == VEC[v], "R3 I stream word", i_rx[v/2], VEC[v]);
      chk(q_rx[v/2] == VEC[v+1], "R3 Q stream word", q_rx[v/2], VEC[v+1]);
    end
    chk(misframe == 0, "R5 strobe run length", misframe, 0);
    chk(bubble == 0, "R5 no idle cycle between words", bubble, 0);
    chk(rd_empty_err == 0, "R2 no pop while empty", rd_empty_err, 0);

    // R6: gap after an odd word count keeps phase
    @(posedge clk_i); rx_clear();
    @(negedge clk_i);
    push(32'h1357_9BDF);
    repeat (50) @(negedge clk_i);
    chk({i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o} == 5'b0, "R6 idle lines low",
        {27'b0, i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o}, 0);
    chk(rd_empty_err == 0, "R2 no pop on empty during gap", rd_empty_err, 0);
    push(32'h2468_ACE0);
    repeat (50) @(negedge clk_i);
    chk(q_n == 1 && q_rx[0] == 32'h2468_ACE0, "R6 word after gap on Q pin", q_rx[0], 32'h2468_ACE0);
    chk(i_n == 1 && i_rx[0] == 32'h1357_9BDF, "R6 word before gap on I pin", i_rx[0], 32'h1357_9BDF);

    // R7/R8: full pulse mid-word, sticky flag, clear
    push(32'hFFFF_FFFF);
    repeat (5) @(negedge clk_i);
    fifo_full_i = 1'b1;
    #1 chk(ovf_o == 1'b1, "R7 ovf high with full", {31'b0, ovf_o}, 1);
    chk({i_ser_o, i_vld_o, q_ser_o, q_vld_o} == 4'b0, "R7 data pins blanked",
        {28'b0, i_ser_o, i_vld_o, q_ser_o, q_vld_o}, 0);
    @(negedge clk_i);
    fifo_full_i = 1'b0;
    #1 chk(ovf_o == 1'b1, "R8 sticky after full drops", {31'b0, ovf_o}, 1);
    chk(i_vld_o && i_ser_o, "R7 shifting resumes", {30'b0, i_vld_o, i_ser_o}, 3);
    repeat (3) @(negedge clk_i);
    chk(ovf_o == 1'b1, "R8 sticky holds", {31'b0, ovf_o}, 1);
    ovf_clr_i = 1'b1;
    @(negedge clk_i);
    ovf_clr_i = 1'b0;
    chk(ovf_o == 1'b0, "R8 clear drops flag", {31'b0, ovf_o}, 0);
    fifo_full_i = 1'b1; ovf_clr_i = 1'b1;
    @(negedge clk_i);
    fifo_full_i = 1'b0; ovf_clr_i = 1'b0;
    #1 chk(ovf_o == 1'b1, "R8 clear loses to full", {31'b0, ovf_o}, 1);

    // R1: reset mid-stream
    push(32'hAAAA_AAAA);
    repeat (40) @(negedge clk_i);
    rst_ni = 1'b0;
    #1 chk({i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o, ovf_o} == 6'b0, "R1 reset clears outputs",
        {26'b0, i_ser_o, i_vld_o, q_ser_o, q_vld_o, fifo_rd_o, ovf_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    @(posedge clk_i); rx_clear();
    @(negedge clk_i);
    push(32'h0BAD_F00D);
    repeat (40) @(negedge clk_i);
    chk(i_n == 1 && q_n == 0 && i_rx[0] == 32'h0BAD_F00D, "R1 phase back to I after reset",
        i_rx[0], 32'h0BAD_F00D);
    finish_run();
  end
endmodule